// File: doc/BRIEF.md
# Configurable Logic Slice

This block is a synthesizable model of a programmable logic slice made of two halves. The lower half produces the X outputs and the upper half produces the Y outputs. Each half has a 4-input lookup table, and static configuration inputs supply its 16-bit truth table. Each half also has a carry-select multiplexer, a sum XOR and a storage flip-flop.

The two table outputs are used in several places at once:
- they steer the carry chain;
- they form arithmetic sums;
- they feed a wide multiplexer that builds any 5-input function;
- they load the flip-flops.

The two bypass pins (BX for the lower half, BY for the upper half) can skip the table, the flip-flop, or both. When enabled, BY also acts as a shared reverse control for both flip-flops.

The slice is used by holding the configuration inputs constant while the data inputs change. Two uses are typical:
- A 2-bit ripple adder: table contents are the XOR of the first two inputs, the carry source is the first input, and the sum is selected onto X and Y.
- An arbitrary 5-input function: the two tables carry the two halves of the truth table, and BX selects between them.

Top module: `lslice_top`

## Requirements
- R1: With the sum not selected for a half (cfg_out_sum bit = 0), X (bit 0) or Y (bit 1) equals that half's table bit at index f_in (lower) or g_in (upper).
- R2: With the sum selected (cfg_out_sum bit = 1), the half's output equals its table bit XOR its incoming carry. The lower half's incoming carry is cin_i. The upper half's incoming carry is the lower half's carry output.
- R3: A half's carry output equals its incoming carry when its table bit is 1. Otherwise it equals the generate source: the half's bypass pin when cfg_gen_lut bit = 0, or the half's first table input (index bit 0) when the bit = 1. cout_o is the upper half's carry output.
- R4: f5_o equals the upper table bit when bx_i = 1, and the lower table bit when bx_i = 0.
- R5: bxout_o always equals bx_i, and byout_o always equals by_i.
- R6: dig_o equals by_i when cfg_dig_en_i = 1, and is 0 otherwise.
- R7: When sr_i = 1 at a rising clock edge, xq_o and yq_o take cfg_init bits 0 and 1. This happens whatever the values of ce_i and by_i.
- R8: When sr_i = 0, cfg_rev_en_i = 1 and by_i = 1 at a rising edge, xq_o and yq_o take cfg_rev_val bits 0 and 1. This happens whatever the value of ce_i.
- R9: When no reset or reverse is active and ce_i = 0, xq_o and yq_o keep their values.
- R10: When no reset or reverse is active and ce_i = 1, each flip-flop loads its table bit if its cfg_d_byp bit = 0, or its bypass pin if the bit = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| sr_i | input | 1 | Synchronous set/reset to init values |
| ce_i | input | 1 | Flip-flop clock enable |
| f_in_i | input | 4 | Lower table inputs |
| g_in_i | input | 4 | Upper table inputs |
| bx_i | input | 1 | Lower bypass pin, wide-mux select |
| by_i | input | 1 | Upper bypass pin, reverse control |
| cin_i | input | 1 | Carry into lower half |
| cfg_f_lut_i | input | 16 | Lower truth table |
| cfg_g_lut_i | input | 16 | Upper truth table |
| cfg_out_sum_i | input | 2 | Per half: output sum instead of table bit |
| cfg_d_byp_i | input | 2 | Per half: flip-flop loads bypass pin |
| cfg_gen_lut_i | input | 2 | Per half: carry generate from table input 0 |
| cfg_init_i | input | 2 | Per half: value forced by sr_i |
| cfg_rev_val_i | input | 2 | Per half: value forced by reverse |
| cfg_rev_en_i | input | 1 | Enable BY as reverse control |
| cfg_dig_en_i | input | 1 | Route BY onto dig_o |
| x_o | output | 1 | Lower combinational output |
| y_o | output | 1 | Upper combinational output |
| xq_o | output | 1 | Lower flip-flop output |
| yq_o | output | 1 | Upper flip-flop output |
| f5_o | output | 1 | Wide 5-input function output |
| bxout_o | output | 1 | BX passed through |
| byout_o | output | 1 | BY passed through |
| dig_o | output | 1 | Gated BY output |
| cout_o | output | 1 | Slice carry out |

## Verification
The assertions check the following on every cycle:
- the bypass pass-through and the gated DIG output;
- the flip-flop priority of set/reset over reverse over enable.

Only the bench's scenarios can show the table, carry and wide-mux behaviour. The bench sweeps every operand of a 2-bit ripple adder and every index of a random 5-input function. It compares the results with arithmetic done in the bench. It also steps the flip-flops through ordered sequences of reset, hold, load and reverse.

// File: rtl/lslice_pkg.sv
package lslice_pkg;

    localparam int HALVES = 2;

    typedef struct packed {
        logic init_val;   // forced on sr
        logic rev_val;    // forced on reverse
        logic out_sum;    // comb output is sum instead of table bit
        logic d_byp;      // flip-flop loads bypass pin
        logic gen_lut;    // carry generate from table input 0
    } half_cfg_t;

    typedef struct packed {
        logic lut;
        logic comb;
        logic cout;
        logic q;
    } half_out_t;

    function automatic logic carry_sel(input logic prop, input logic cin, input logic gen);
        return prop ? cin : gen;
    endfunction

endpackage

// File: rtl/lslice_lut.sv
module lslice_lut #(
    parameter int LUT_IN = 4,
    localparam int LUT_SIZE = 1 << LUT_IN
) (
    input  logic [LUT_SIZE-1:0] table_i,
    input  logic [LUT_IN-1:0]   idx_i,
    output logic                bit_o
);
    assign bit_o = table_i[idx_i];
endmodule

// File: rtl/lslice_half.sv
module lslice_half
    import lslice_pkg::*;
#(
    parameter int LUT_IN = 4,
    localparam int LUT_SIZE = 1 << LUT_IN
) (
    input  logic                clk_i,
    input  logic                sr_i,
    input  logic                rev_i,
    input  logic                ce_i,
    input  logic [LUT_SIZE-1:0] table_i,
    input  logic [LUT_IN-1:0]   idx_i,
    input  logic                byp_i,
    input  logic                cin_i,
    input  half_cfg_t           cfg_i,
    output half_out_t           out_o
);
    logic lut_bit;
    logic gen_bit;
    logic d_bit;
    logic q_r;

    lslice_lut #(.LUT_IN(LUT_IN)) lut_i (
        .table_i (table_i),
        .idx_i   (idx_i),
        .bit_o   (lut_bit)
    );

    always_comb begin
        gen_bit    = cfg_i.gen_lut ? idx_i[0] : byp_i;
        d_bit      = cfg_i.d_byp ? byp_i : lut_bit;
        out_o.lut  = lut_bit;
        out_o.comb = cfg_i.out_sum ? (lut_bit ^ cin_i) : lut_bit;
        out_o.cout = carry_sel(lut_bit, cin_i, gen_bit);
        out_o.q    = q_r;
    end

    always_ff @(posedge clk_i) begin
        if (sr_i) begin
            q_r <= cfg_i.init_val;
        end else if (rev_i) begin
            q_r <= cfg_i.rev_val;
        end else if (ce_i) begin
            q_r <= d_bit;
        end
    end
endmodule

// File: rtl/lslice_top.sv
module lslice_top
    import lslice_pkg::*;
#(
    parameter int LUT_IN = 4,
    localparam int LUT_SIZE = 1 << LUT_IN
) (
    input  logic                clk_i,
    input  logic                sr_i,
    input  logic                ce_i,
    input  logic [LUT_IN-1:0]   f_in_i,
    input  logic [LUT_IN-1:0]   g_in_i,
    input  logic                bx_i,
    input  logic                by_i,
    input  logic                cin_i,
    input  logic [LUT_SIZE-1:0] cfg_f_lut_i,
    input  logic [LUT_SIZE-1:0] cfg_g_lut_i,
    input  logic [HALVES-1:0]   cfg_out_sum_i,
    input  logic [HALVES-1:0]   cfg_d_byp_i,
    input  logic [HALVES-1:0]   cfg_gen_lut_i,
    input  logic [HALVES-1:0]   cfg_init_i,
    input  logic [HALVES-1:0]   cfg_rev_val_i,
    input  logic                cfg_rev_en_i,
    input  logic                cfg_dig_en_i,
    output logic                x_o,
    output logic                y_o,
    output logic                xq_o,
    output logic                yq_o,
    output logic                f5_o,
    output logic                bxout_o,
    output logic                byout_o,
    output logic                dig_o,
    output logic                cout_o
);
    logic [LUT_SIZE-1:0] tables [HALVES];
    logic [LUT_IN-1:0]   idxs   [HALVES];
    logic [HALVES-1:0]   byps;
    logic [HALVES:0]     carry;
    half_out_t           outs   [HALVES];
    logic                rev_act;

    assign tables[0] = cfg_f_lut_i;
    assign tables[1] = cfg_g_lut_i;
    assign idxs[0]   = f_in_i;
    assign idxs[1]   = g_in_i;
    assign byps      = {by_i, bx_i};
    assign carry[0]  = cin_i;
    assign rev_act   = cfg_rev_en_i & by_i;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        half_cfg_t hcfg;
        assign hcfg = '{init_val: cfg_init_i[h], rev_val: cfg_rev_val_i[h],
                        out_sum: cfg_out_sum_i[h], d_byp: cfg_d_byp_i[h],
                        gen_lut: cfg_gen_lut_i[h]};
        lslice_half #(.LUT_IN(LUT_IN)) half_i (
            .clk_i   (clk_i),
            .sr_i    (sr_i),
            .rev_i   (rev_act),
            .ce_i    (ce_i),
            .table_i (tables[h]),
            .idx_i   (idxs[h]),
            .byp_i   (byps[h]),
            .cin_i   (carry[h]),
            .cfg_i   (hcfg),
            .out_o   (outs[h])
        );
        assign carry[h+1] = outs[h].cout;
    end

    assign x_o     = outs[0].comb;
    assign y_o     = outs[1].comb;
    assign xq_o    = outs[0].q;
    assign yq_o    = outs[1].q;
    assign f5_o    = bx_i ? outs[1].lut : outs[0].lut;
    assign bxout_o = bx_i;
    assign byout_o = by_i;
    assign dig_o   = cfg_dig_en_i & by_i;
    assign cout_o  = carry[HALVES];
endmodule

// File: rtl/lslice_chk.sv
module lslice_chk (
    input logic       clk_i,
    input logic       sr_i,
    input logic       ce_i,
    input logic       bx_i,
    input logic       by_i,
    input logic [1:0] cfg_init_i,
    input logic [1:0] cfg_rev_val_i,
    input logic       cfg_rev_en_i,
    input logic       cfg_dig_en_i,
    input logic       xq_o,
    input logic       yq_o,
    input logic       bxout_o,
    input logic       byout_o,
    input logic       dig_o
);
    p_bypass_r5: assert property (@(posedge clk_i) disable iff (sr_i)
        (bxout_o == bx_i) && (byout_o == by_i));

    p_dig_gate_r6: assert property (@(posedge clk_i) disable iff (sr_i)
        dig_o == (cfg_dig_en_i & by_i));

    p_sr_init_r7: assert property (@(posedge clk_i) disable iff (sr_i)
        $past(sr_i) |-> ({yq_o, xq_o} == $past(cfg_init_i)));

    p_rev_force_r8: assert property (@(posedge clk_i) disable iff (sr_i)
        (cfg_rev_en_i && by_i) |=> ({yq_o, xq_o} == $past(cfg_rev_val_i)));

    p_ce_hold_r9: assert property (@(posedge clk_i) disable iff (sr_i)
        (!ce_i && !(cfg_rev_en_i && by_i)) |=> ($stable(xq_o) && $stable(yq_o)));
endmodule

bind lslice_top lslice_chk chk_i (
    .clk_i         (clk_i),
    .sr_i          (sr_i),
    .ce_i          (ce_i),
    .bx_i          (bx_i),
    .by_i          (by_i),
    .cfg_init_i    (cfg_init_i),
    .cfg_rev_val_i (cfg_rev_val_i),
    .cfg_rev_en_i  (cfg_rev_en_i),
    .cfg_dig_en_i  (cfg_dig_en_i),
    .xq_o          (xq_o),
    .yq_o          (yq_o),
    .bxout_o       (bxout_o),
    .byout_o       (byout_o),
    .dig_o         (dig_o)
);

// File: tb/lslice_top_tb_top.sv
`timescale 1ns/1ps
module lslice_top_tb_top;
    logic clk = 1'b0;
    logic sr, ce, bx, by, cin;
    logic [3:0] f_in, g_in;
    logic [15:0] f_lut, g_lut;
    logic [1:0] out_sum, d_byp, gen_lut, init_v, rev_v;
    logic rev_en, dig_en;
    logic x, y, xq, yq, f5, bxout, byout, dig, cout;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lslice_top dut_i (
        .clk_i(clk), .sr_i(sr), .ce_i(ce), .f_in_i(f_in), .g_in_i(g_in),
        .bx_i(bx), .by_i(by), .cin_i(cin), .cfg_f_lut_i(f_lut), .cfg_g_lut_i(g_lut),
        .cfg_out_sum_i(out_sum), .cfg_d_byp_i(d_byp), .cfg_gen_lut_i(gen_lut),
        .cfg_init_i(init_v), .cfg_rev_val_i(rev_v), .cfg_rev_en_i(rev_en),
        .cfg_dig_en_i(dig_en), .x_o(x), .y_o(y), .xq_o(xq), .yq_o(yq), .f5_o(f5),
        .bxout_o(bxout), .byout_o(byout), .dig_o(dig), .cout_o(cout)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic edge_step();
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] func;
        sr = 1; ce = 0; bx = 0; by = 0; cin = 0; f_in = 0; g_in = 0;
        f_lut = 0; g_lut = 0; out_sum = 0; d_byp = 0; gen_lut = 0;
        init_v = 2'b10; rev_v = 2'b01; rev_en = 0; dig_en = 0;
        edge_step();
        // R7 reset state
        check("R7 reset", {6'd0, yq, xq}, 8'b10);

        // R1 raw table outputs
        sr = 0;
        f_lut = 16'hA5C3; g_lut = 16'h3C96;
        for (int i = 0; i < 16; i++) begin
            f_in = 4'(i); g_in = 4'(15 - i); #1;
            check("R1 x", {7'd0, x}, {7'd0, f_lut[i]});
            check("R1 y", {7'd0, y}, {7'd0, g_lut[15 - i]});
        end

        // R2/R3 2-bit ripple adder
        f_lut = 16'h6666; g_lut = 16'h6666; out_sum = 2'b11; gen_lut = 2'b11;
        for (int v = 0; v < 32; v++) begin
            logic [1:0] a, b;
            logic [2:0] s;
            a = v[1:0]; b = v[3:2]; cin = v[4];
            f_in = {2'b00, b[0], a[0]}; g_in = {2'b00, b[1], a[1]}; #1;
            s = 3'(a) + 3'(b) + 3'(cin);
            check("R2 sum", {6'd0, y, x}, {6'd0, s[1:0]});
            check("R3 carry", {7'd0, cout}, {7'd0, s[2]});
        end

        // R3 generate from bypass pins
        out_sum = 2'b00; gen_lut = 2'b00; f_lut = 16'h0000; g_lut = 16'h0000;
        for (int v = 0; v < 8; v++) begin
            cin = v[0]; bx = v[1]; by = v[2]; #1;
            check("R3 gen by", {7'd0, cout}, {7'd0, by});
        end
        g_lut = 16'hFFFF;
        for (int v = 0; v < 8; v++) begin
            cin = v[0]; bx = v[1]; by = v[2]; #1;
            check("R3 gen bx", {7'd0, cout}, {7'd0, bx});
        end
        f_lut = 16'hFFFF;
        for (int v = 0; v < 8; v++) begin
            cin = v[0]; bx = v[1]; by = v[2]; #1;
            check("R3 prop", {7'd0, cout}, {7'd0, cin});
        end

        // R4 arbitrary 5-input function
        func = 32'hD3A9_5E71;
        f_lut = func[15:0]; g_lut = func[31:16];
        for (int v = 0; v < 32; v++) begin
            bx = v[4]; f_in = v[3:0]; g_in = v[3:0]; #1;
            check("R4 f5", {7'd0, f5}, {7'd0, func[v]});
        end

        // R5/R6 bypass and DIG
        for (int v = 0; v < 8; v++) begin
            bx = v[0]; by = v[1]; dig_en = v[2]; #1;
            check("R5 bxout", {7'd0, bxout}, {7'd0, bx});
            check("R5 byout", {7'd0, byout}, {7'd0, by});
            check("R6 dig", {7'd0, dig}, {7'd0, by & dig_en});
        end
        dig_en = 0; bx = 0; by = 0;

        // R9 hold with ce low
        f_lut = 16'hFFFF; g_lut = 16'h0000; ce = 0;
        edge_step();
        check("R9 hold", {6'd0, yq, xq}, 8'b10);

        // R10 load table bits
        ce = 1; d_byp = 2'b00;
        edge_step();
        check("R10 load lut", {6'd0, yq, xq}, 8'b01);

        // R10 load bypass pins
        d_byp = 2'b11; bx = 0; by = 1;
        edge_step();
        check("R10 load byp", {6'd0, yq, xq}, 8'b10);

        // R8 reverse overrides ce low
        ce = 0; rev_en = 1; rev_v = 2'b01; by = 1;
        edge_step();
        check("R8 reverse", {6'd0, yq, xq}, 8'b01);
        rev_v = 2'b10;
        edge_step();
        check("R8 reverse2", {6'd0, yq, xq}, 8'b10);

        // R7 reset beats reverse
        init_v = 2'b01; sr = 1;
        edge_step();
        check("R7 sr prio", {6'd0, yq, xq}, 8'b01);
        sr = 0; by = 0; rev_en = 0;
        edge_step();
        check("R9 hold after", {6'd0, yq, xq}, 8'b01);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule